// File: doc/BRIEF.md
# Eight-Channel Switch Protection Controller

This block holds the digital control and protection logic for an eight-channel low-side switch. Each channel's on/off command comes from a serially written on/off register or from one of four parallel pins. The pins have a programmable polarity. The last pin can be steered to any channel. Each channel has a current-limit-active flag and an overtemperature flag. A per-channel overload policy turns these into a gate enable and a sticky fault bit. An active-low summary fault output follows the fault register.

Each channel runs a four-state machine. **OFF** leaves the gate disabled. **ON** drives the gate. **LIMIT** drives the gate while a counter measures how long current limiting has lasted. **LATCH** holds the gate off after an overload shutdown.

The transitions are as follows:
- *power-up*: OFF to ON when the command is active.
- *release*: ON or LIMIT to OFF when the command drops.
- *limit-enter*: ON to LIMIT when the limit flag is seen.
- *limit-exit*: LIMIT to ON when the limit flag drops before the shutdown threshold. This also restarts the count.
- *trip*: ON or LIMIT to LATCH when the channel is in shutdown mode and limiting reaches the switch-off delay.
- *rearm*: LATCH to ON on a low-to-high edge of the channel's controlling command.

The active-low reset puts every channel in OFF and clears all registers. Overtemperature gates the output off in any state.

Top module: `octal_switch_ctrl`

## Requirements
- R1: With the channel's mode bit at 0 (limit-only), if the limit flag is sampled high on FILT_CYC consecutive clock edges while the channel is on, the channel's fault bit sets on that edge. The gate stays enabled for as long as the command holds.
- R2: With the mode bit at 1 (shutdown), if the limit flag is sampled high on SHDN_CYC consecutive edges, the gate turns off on that edge and the fault bit sets. The gate stays off after the limit flag drops.
- R3: A latched channel is re-enabled only by a low-to-high transition of its controlling command. For a channel under parallel control this is the parallel pin. Otherwise it is its on/off register bit. Rewriting an unchanged 1 does not release it.
- R4: While overtemperature is high and the channel is commanded on, the gate is off in the same cycle and the fault bit sets at the next edge. Overtemperature on a channel commanded off sets no fault.
- R5: While rst_n is low, all gates are off and the on/off and fault registers read 0. Configuration returns to mode 0 on all channels, map 3 and all parallel enables set. After release, register-driven channels stay off and parallel-driven channels follow their pins.
- R6: When pol is 1, a parallel pin is active at 1. When pol is 0, it is active at 0.
- R7: Bits are numbered from channel 1 at bit 0. Parallel pins 0 to 2 control channels at bits 0 to 2 when their bit in cfg_par_en is set. Pin 3, when enabled, controls the channel whose index equals cfg_map, and it overrides any other source for that channel. Every other channel uses its on/off register bit.
- R8: fault_n is 0 whenever any fault bit is 1, and 1 otherwise.
- R9: A one-cycle flt_rd clears the fault register on its edge. A bit whose condition is present on that edge stays set. A condition counts as present if limiting is past its threshold, the channel is latched off, or overtemperature is high while the channel is commanded on.
- R10: If the limit flag drops before a threshold is reached, the count restarts from zero at the next limit episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset / sleep |
| pol | input | 1 | Parallel pin polarity: 1 active-high, 0 active-low (tie high when unused) |
| par_in | input | N_PAR | Parallel command pins |
| onoff_we | input | 1 | Write strobe for the on/off register |
| onoff_wdata | input | N_CH | On/off register write data |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | N_CH | Per-channel policy: 0 limit-only, 1 shutdown |
| cfg_map | input | clog2(N_CH) | Target channel index of the last parallel pin |
| cfg_par_en | input | N_PAR | Per-pin parallel control enable |
| flt_rd | input | 1 | Fault register read strobe (clear) |
| ilim | input | N_CH | Current-limit-active flags |
| otemp | input | N_CH | Overtemperature flags |
| gate_en | output | N_CH | Per-channel gate enable |
| fault_reg | output | N_CH | Sticky fault register |
| fault_n | output | 1 | Active-low summary fault |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a fault-register read and a still-present fault condition. The bench issues flt_rd while limiting persists past the filter time, and again while a channel is latched. It expects the bit to survive. It repeats the read once the condition has gone and expects the bit to clear. The second pair is a latched channel and a rewrite of its command: an unchanged 1 must leave it latched, and only a 0-then-1 sequence on the serial bit or the parallel pin must rearm it.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ON    = 2'd1,
        CH_LIMIT = 2'd2,
        CH_LATCH = 2'd3
    } ch_state_t;
endpackage

// File: rtl/sw_regs.sv
module sw_regs #(
    parameter int N_CH    = 8,
    parameter int N_PAR   = 4,
    parameter int DEF_MAP = 3,
    localparam int MAP_W  = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             onoff_we,
    input  logic [N_CH-1:0]  onoff_wdata,
    input  logic             cfg_we,
    input  logic [N_CH-1:0]  cfg_mode,
    input  logic [MAP_W-1:0] cfg_map,
    input  logic [N_PAR-1:0] cfg_par_en,
    input  logic             flt_rd,
    input  logic [N_CH-1:0]  flt_cond,
    output logic [N_CH-1:0]  onoff_q,
    output logic [N_CH-1:0]  mode_q,
    output logic [MAP_W-1:0] map_q,
    output logic [N_PAR-1:0] pen_q,
    output logic [N_CH-1:0]  fault_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            onoff_q <= '0;
            mode_q  <= '0;
            map_q   <= MAP_W'(DEF_MAP);
            pen_q   <= '1;
            fault_q <= '0;
        end else begin
            if (onoff_we) onoff_q <= onoff_wdata;
            if (cfg_we) begin
                mode_q <= cfg_mode;
                map_q  <= cfg_map;
                pen_q  <= cfg_par_en;
            end
            fault_q <= (fault_q & ~{N_CH{flt_rd}}) | flt_cond;
        end
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_rd |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R9
    AST_ONOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !onoff_we |=> $stable(onoff_q)); // R3
endmodule

// File: rtl/sw_cmd_route.sv
module sw_cmd_route #(
    parameter int N_CH   = 8,
    parameter int N_PAR  = 4,
    localparam int MAP_W = $clog2(N_CH)
) (
    input  logic             pol,
    input  logic [N_PAR-1:0] par_in,
    input  logic [N_PAR-1:0] pen_q,
    input  logic [MAP_W-1:0] map_q,
    input  logic [N_CH-1:0]  onoff_q,
    output logic [N_CH-1:0]  cmd
);
    localparam int LAST = N_PAR - 1;

    logic [N_PAR-1:0] act;
    assign act = pol ? par_in : ~par_in;

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic mapped;
        assign mapped = pen_q[LAST] && (map_q == MAP_W'(k));
        if (k < LAST) begin : g_direct
            always_comb begin
                if (mapped)        cmd[k] = act[LAST];
                else if (pen_q[k]) cmd[k] = act[k];
                else               cmd[k] = onoff_q[k];
            end
        end else begin : g_serial
            always_comb begin
                if (mapped) cmd[k] = act[LAST];
                else        cmd[k] = onoff_q[k];
            end
        end
    end
endmodule

// File: rtl/sw_channel.sv
module sw_channel
    import sw_pkg::*;
#(
    parameter int FILT_CYC = 64,
    parameter int SHDN_CYC = 200,
    localparam int MAXC    = (FILT_CYC > SHDN_CYC) ? FILT_CYC : SHDN_CYC,
    localparam int CW      = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic mode,
    input  logic ilim,
    input  logic otemp,
    output logic gate,
    output logic flt_cond
);
    ch_state_t     st, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          cmd_d;
    logic [CW:0]   cnt_inc, thr;
    logic          over, rise;

    assign cnt_inc = {1'b0, cnt} + (CW+1)'(1);
    assign thr     = mode ? (CW+1)'(SHDN_CYC) : (CW+1)'(FILT_CYC);
    assign over    = ((st == CH_ON) || (st == CH_LIMIT)) && ilim && (cnt_inc >= thr);
    assign rise    = cmd && !cmd_d;

    always_comb begin
        nxt = st;
        unique case (st)
            CH_OFF:   if (cmd) nxt = CH_ON;
            CH_ON: begin
                if (!cmd)              nxt = CH_OFF;
                else if (over && mode) nxt = CH_LATCH;
                else if (ilim)         nxt = CH_LIMIT;
            end
            CH_LIMIT: begin
                if (!cmd)              nxt = CH_OFF;
                else if (over && mode) nxt = CH_LATCH;
                else if (!ilim)        nxt = CH_ON;
            end
            CH_LATCH: if (rise) nxt = CH_ON;
        endcase
        if (nxt != CH_LIMIT)
            cnt_nxt = '0;
        else if (cnt_inc > (CW+1)'(MAXC))
            cnt_nxt = cnt;
        else
            cnt_nxt = cnt_inc[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= CH_OFF;
            cnt   <= '0;
            cmd_d <= 1'b0;
        end else begin
            st    <= nxt;
            cnt   <= cnt_nxt;
            cmd_d <= cmd;
        end
    end

    always_comb begin
        gate     = ((st == CH_ON) || (st == CH_LIMIT)) && !otemp;
        flt_cond = over || (st == CH_LATCH) || (otemp && cmd);
    end

    AST_LIMIT_ONLY_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && st != CH_LATCH) |=> (st != CH_LATCH)); // R1
    AST_TRIP_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && over && cmd) |=> (st == CH_LATCH && !gate)); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_LATCH && !rise) |=> (st == CH_LATCH)); // R3
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_LIMIT) |-> (cnt == '0)); // R10
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl #(
    parameter int N_CH     = 8,
    parameter int N_PAR    = 4,
    parameter int FILT_CYC = 64,
    parameter int SHDN_CYC = 200,
    parameter int DEF_MAP  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pol,
    input  logic [N_PAR-1:0]        par_in,
    input  logic                    onoff_we,
    input  logic [N_CH-1:0]         onoff_wdata,
    input  logic                    cfg_we,
    input  logic [N_CH-1:0]         cfg_mode,
    input  logic [$clog2(N_CH)-1:0] cfg_map,
    input  logic [N_PAR-1:0]        cfg_par_en,
    input  logic                    flt_rd,
    input  logic [N_CH-1:0]         ilim,
    input  logic [N_CH-1:0]         otemp,
    output logic [N_CH-1:0]         gate_en,
    output logic [N_CH-1:0]         fault_reg,
    output logic                    fault_n
);
    localparam int MAP_W = $clog2(N_CH);

    logic [N_CH-1:0]  onoff_q, mode_q, cmd, flt_cond;
    logic [MAP_W-1:0] map_q;
    logic [N_PAR-1:0] pen_q;

    sw_regs #(.N_CH(N_CH), .N_PAR(N_PAR), .DEF_MAP(DEF_MAP)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .onoff_we(onoff_we), .onoff_wdata(onoff_wdata),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_map(cfg_map), .cfg_par_en(cfg_par_en),
        .flt_rd(flt_rd), .flt_cond(flt_cond),
        .onoff_q(onoff_q), .mode_q(mode_q), .map_q(map_q), .pen_q(pen_q),
        .fault_q(fault_reg)
    );

    sw_cmd_route #(.N_CH(N_CH), .N_PAR(N_PAR)) i_route (
        .pol(pol), .par_in(par_in), .pen_q(pen_q), .map_q(map_q),
        .onoff_q(onoff_q), .cmd(cmd)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_chan
        sw_channel #(.FILT_CYC(FILT_CYC), .SHDN_CYC(SHDN_CYC)) i_chan (
            .clk(clk), .rst_n(rst_n), .cmd(cmd[k]), .mode(mode_q[k]),
            .ilim(ilim[k]), .otemp(otemp[k]),
            .gate(gate_en[k]), .flt_cond(flt_cond[k])
        );
    end

    assign fault_n = ~|fault_reg;

    AST_RESET_GATES_OFF: assert property (@(posedge clk)
        !rst_n |-> (gate_en == '0)); // R5
    AST_HOT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((otemp & gate_en) == '0)); // R4
endmodule

// File: tb/test_octal_switch_ctrl.sv
`timescale 1ns/100ps
module test_octal_switch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pol = 1'b1;
    logic [3:0] par_in = '0;
    logic       onoff_we = 1'b0;
    logic [7:0] onoff_wdata = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_mode = '0;
    logic [2:0] cfg_map = 3'd3;
    logic [3:0] cfg_par_en = 4'hF;
    logic       flt_rd = 1'b0;
    logic [7:0] ilim = '0;
    logic [7:0] otemp = '0;
    logic [7:0] gate_en, fault_reg;
    logic       fault_n;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    octal_switch_ctrl #(.FILT_CYC(4), .SHDN_CYC(6)) i_octal_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .pol(pol), .par_in(par_in),
        .onoff_we(onoff_we), .onoff_wdata(onoff_wdata),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_map(cfg_map), .cfg_par_en(cfg_par_en),
        .flt_rd(flt_rd), .ilim(ilim), .otemp(otemp),
        .gate_en(gate_en), .fault_reg(fault_reg), .fault_n(fault_n)
    );

    // {pol, par_in, par_en, map, onoff, expected gate_en}
    localparam logic [27:0] VECS [9] = '{
        {1'b1, 4'b0000, 4'b1111, 3'd3, 8'h00, 8'h00},
        {1'b1, 4'b0101, 4'b1111, 3'd3, 8'h00, 8'h05},
        {1'b0, 4'b0101, 4'b1111, 3'd3, 8'h00, 8'h0A},
        {1'b1, 4'b1000, 4'b1111, 3'd6, 8'h00, 8'h40},
        {1'b1, 4'b1000, 4'b1111, 3'd6, 8'h08, 8'h48},
        {1'b1, 4'b0000, 4'b0000, 3'd3, 8'hF0, 8'hF0},
        {1'b1, 4'b1111, 4'b0000, 3'd3, 8'h03, 8'h03},
        {1'b1, 4'b1000, 4'b1000, 3'd0, 8'h02, 8'h03},
        {1'b0, 4'b1111, 4'b1111, 3'd7, 8'hFF, 8'h78}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_onoff(input logic [7:0] v);
        onoff_wdata = v; onoff_we = 1'b1;
        step(1);
        onoff_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] m, input logic [2:0] mp, input logic [3:0] en);
        cfg_mode = m; cfg_map = mp; cfg_par_en = en; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd_pulse();
        flt_rd = 1'b1;
        step(1);
        flt_rd = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            summary();
        end
    end

    initial begin
        step(3);
        chk("R5 reset gates", gate_en, 8'h00);
        chk("R5 reset faults", fault_reg, 8'h00);
        chk("R8 fault_n idle", fault_n, 1'b1);
        rst_n = 1'b1;
        step(2);

        // R6 R7 routing and polarity table
        foreach (VECS[i]) begin
            pol = VECS[i][27];
            par_in = VECS[i][26:23];
            wr_cfg(8'h00, VECS[i][18:16], VECS[i][22:19]);
            wr_onoff(VECS[i][15:8]);
            step(2);
            chk("R6/R7 routing vector", gate_en, {24'h0, VECS[i][7:0]});
        end

        // setup: parallel channels idle, serial channel 5 (bit 4) on
        pol = 1'b1; par_in = 4'b0000;
        wr_cfg(8'h00, 3'd3, 4'hF);
        wr_onoff(8'h10);
        step(2);
        chk("R7 serial ch5 on", gate_en, 8'h10);

        // R1 limit-only
        ilim[4] = 1'b1;
        step(3);
        chk("R1 before filter", fault_reg, 8'h00);
        step(1);
        chk("R1 fault at filter", fault_reg, 8'h10);
        chk("R1 gate kept", gate_en, 8'h10);
        chk("R8 fault_n low", fault_n, 1'b0);
        step(5);
        chk("R1 gate still on", gate_en, 8'h10);

        // R9 read while condition present, then after it goes
        rd_pulse();
        chk("R9 kept while limiting", fault_reg, 8'h10);
        ilim[4] = 1'b0;
        step(1);
        rd_pulse();
        chk("R9 cleared", fault_reg, 8'h00);
        chk("R8 fault_n released", fault_n, 1'b1);

        // R10 restart on interruption
        ilim[4] = 1'b1; step(3);
        ilim[4] = 1'b0; step(1);
        ilim[4] = 1'b1; step(3);
        chk("R10 count restarted", fault_reg, 8'h00);
        step(1);
        chk("R10 fault after full run", fault_reg, 8'h10);
        ilim[4] = 1'b0; step(1);
        rd_pulse();

        // R2 shutdown mode
        wr_cfg(8'h10, 3'd3, 4'hF);
        ilim[4] = 1'b1;
        step(5);
        chk("R2 before delay gate", gate_en, 8'h10);
        chk("R2 before delay fault", fault_reg, 8'h00);
        step(1);
        chk("R2 trip gate", gate_en, 8'h00);
        chk("R2 trip fault", fault_reg, 8'h10);
        ilim[4] = 1'b0;
        step(2);
        chk("R2 stays off", gate_en, 8'h00);

        // R3 serial rearm, R9 latched bit survives read
        rd_pulse();
        chk("R9 kept while latched", fault_reg, 8'h10);
        wr_onoff(8'h10);
        step(2);
        chk("R3 rewrite 1 no rearm", gate_en, 8'h00);
        wr_onoff(8'h00);
        step(1);
        wr_onoff(8'h10);
        step(1);
        chk("R3 serial rearm", gate_en, 8'h10);
        rd_pulse();
        chk("R9 cleared after rearm", fault_reg, 8'h00);

        // R4 overtemperature
        otemp[4] = 1'b1;
        #1;
        chk("R4 gate off same cycle", gate_en, 8'h00);
        step(1);
        chk("R4 fault set", fault_reg, 8'h10);
        otemp[4] = 1'b0;
        #1;
        chk("R4 gate back", gate_en, 8'h10);
        rd_pulse();
        otemp[5] = 1'b1;
        step(2);
        chk("R4 ignored when off", fault_reg, 8'h00);
        otemp[5] = 1'b0;

        // R3 parallel rearm on channel 1
        wr_cfg(8'h01, 3'd3, 4'hF);
        par_in = 4'b0001;
        step(2);
        chk("R3 par ch1 on", gate_en[0], 1'b1);
        ilim[0] = 1'b1;
        step(6);
        chk("R3 par ch1 tripped", gate_en[0], 1'b0);
        ilim[0] = 1'b0;
        step(2);
        chk("R3 par held high no rearm", gate_en[0], 1'b0);
        par_in = 4'b0000; step(1);
        par_in = 4'b0001; step(1);
        chk("R3 par rearm", gate_en[0], 1'b1);

        // R5 reset mid-operation
        ilim[0] = 1'b1; step(6); ilim[0] = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R5 async gates off", gate_en, 8'h00);
        chk("R5 async faults clear", fault_reg, 8'h00);
        par_in = 4'b1001;
        step(1);
        rst_n = 1'b1;
        step(2);
        chk("R5 after release", gate_en, 8'h09);

        done = 1'b1;
        summary();
    end
endmodule